// File: doc/BRIEF.md
# Strobed Parallel Peripheral Bus Slave

This block gives a microcontroller register access to four on-chip peripherals: the card UART, the clock generator, the activation sequencer and an auxiliary RAM window. The controller uses an 8-bit data bus, a 4-bit register address, a read/write select and an active-low enable strobe. The strobe is not tied to the block's clock, so it is brought into the system clock domain through a two-flop synchroniser. The address and data are sampled while the synchronised enable is low. The bus is modelled as separate input, output and output-enable signals, and the pad ring joins them.

For a read, the block drives the addressed register onto the bus while enable is low and stops driving after enable returns high. For a write, the data must be valid before enable falls. The write is committed as a one-cycle strobe to the peripheral that owns the address, one cycle after the synchronised rising edge of enable. One active-low interrupt line is shared by all four peripherals. Any peripheral event pulls it low. It is released by the rising enable edge that ends a read of the UART status register, so the value read out is not lost.

Top module: `strobe_bus_slave`

## Requirements
- R1: During and just after reset, busDataOe is 0, irqN is 1 and wrSel is all zero.
- R2: With busRdWr=1 held and busEnN low, busDataOe is 1 within 3 clock cycles, and busDataOut carries regRdData bits [8*a+7:8*a] for mapped address a.
- R3: Within 3 clock cycles of busEnN returning high, busDataOe is 0.
- R4: A write (busRdWr=0) produces wrSel high for exactly one cycle, 3 cycles after busEnN rises. wrData equals the data held on busDataIn while enable was low, and wrOffset equals address bit 0.
- R5: No write strobe appears while enable is still low, and none appears for a read.
- R6: A read of an unmapped address (8 to 15) returns 8'hFF.
- R7: A write to an unmapped address (8 to 15) produces no write strobe.
- R8: A pulse on any irqEvent bit drives irqN low on the next cycle, and irqN stays low until it is cleared.
- R9: irqN returns high only on the enable rising edge that ends a read of status address 1. That read returns the status register value, and a read of any other address leaves irqN low.
- R10: If an irqEvent pulse lands in the same cycle as a status-read clear, the event wins and irqN stays low.
- R11: Address bits [3:1] select the peripheral, one-hot on wrSel: 0 is the UART, 1 the clock generator, 2 the sequencer and 3 the RAM window.
- R12: busDataOe stays 0 throughout a write access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busEnN | input | 1 | Active-low access strobe from the controller (asynchronous) |
| busRdWr | input | 1 | 1 = read, 0 = write |
| busAddr | input | 4 | Register address |
| busDataIn | input | 8 | Data from the bus pads |
| busDataOut | output | 8 | Read data toward the bus pads |
| busDataOe | output | 1 | Pad output enable; 0 = bus released |
| irqN | output | 1 | Shared active-low interrupt line |
| regRdData | input | 64 | Current register values, 8 bits per mapped address, address 0 in the lowest byte |
| irqEvent | input | 4 | One-cycle interrupt requests, one per peripheral |
| wrSel | output | 4 | One-cycle one-hot write strobe per peripheral |
| wrOffset | output | 1 | Register offset within the selected peripheral |
| wrData | output | 8 | Write data that goes with wrSel |

## Verification
Two functions can act on the interrupt flag in the same clock edge: a peripheral event that sets it, and the rising enable that ends a status read and clears it. The bench raises enable at a known clock phase and counts the synchroniser stages. It then places the irqEvent pulse exactly on the clock edge where the clear commits. irqN must still be low afterwards, and a second status read must then release it.

// File: rtl/strobe_bus_pkg.sv
package strobe_bus_pkg;

  // Strobes from the control side to the datapath
  typedef struct packed {
    logic capture;  // synchronised enable is low: sample address, direction, data
    logic commit;   // synchronised enable has just risen: finish the access
  } busStrobes_t;

endpackage

// File: rtl/strobe_bus_ctrl.sv
module strobe_bus_ctrl
  import strobe_bus_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busEnN,
  output busStrobes_t strobes
);

  logic [SYNC_STAGES-1:0] enChain;
  logic                   enPrev;
  logic                   enSync;

  // Synchroniser chain for the asynchronous strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enChain <= '1;
      enPrev  <= 1'b1;
    end else begin
      enChain <= {enChain[SYNC_STAGES-2:0], busEnN};
      enPrev  <= enSync;
    end
  end

  assign enSync = enChain[SYNC_STAGES-1];

  always_comb begin
    strobes.capture = ~enSync;
    strobes.commit  = enSync & ~enPrev;
  end

endmodule

// File: rtl/strobe_bus_dpath.sv
module strobe_bus_dpath
  import strobe_bus_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 4,
  parameter int NUM_PERIPH  = 4,
  parameter int OFFSET_W    = 1,
  parameter int STATUS_ADDR = 1,
  localparam int NUM_REGS   = NUM_PERIPH << OFFSET_W,
  localparam int PIDX_W     = ADDR_W - OFFSET_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  busStrobes_t                strobes,
  input  logic                       busRdWr,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic [DATA_W-1:0]          busDataIn,
  output logic [DATA_W-1:0]          busDataOut,
  output logic                       busDataOe,
  output logic                       irqN,
  input  logic [NUM_REGS*DATA_W-1:0] regRdData,
  input  logic [NUM_PERIPH-1:0]      irqEvent,
  output logic [NUM_PERIPH-1:0]      wrSel,
  output logic [OFFSET_W-1:0]        wrOffset,
  output logic [DATA_W-1:0]          wrData
);

  logic [ADDR_W-1:0]     addrQ;
  logic                  rwQ;
  logic [DATA_W-1:0]     dataQ;
  logic [DATA_W-1:0]     readVal;
  logic [NUM_PERIPH-1:0] hitVec;
  logic                  irqPending;
  logic                  clearHit;

  // Sample the access while the synchronised enable is low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      rwQ   <= 1'b1;
      dataQ <= '0;
    end else if (strobes.capture) begin
      addrQ <= busAddr;
      rwQ   <= busRdWr;
      dataQ <= busDataIn;
    end
  end

  // Read multiplexer; unmapped addresses read as all ones
  always_comb begin
    readVal = '1;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (int'(busAddr) == i) readVal = regRdData[i*DATA_W +: DATA_W];
    end
  end

  // Bus drive: only during a read with the enable held low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busDataOe  <= 1'b0;
      busDataOut <= '1;
    end else begin
      busDataOe  <= strobes.capture & busRdWr;
      busDataOut <= readVal;
    end
  end

  // Peripheral decode, one comparator per peripheral
  for (genvar g = 0; g < NUM_PERIPH; g++) begin : gDecode
    assign hitVec[g] = (addrQ[ADDR_W-1:OFFSET_W] == PIDX_W'(g));
  end

  // Write commit at the end of the access
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrSel    <= '0;
      wrOffset <= '0;
      wrData   <= '0;
    end else begin
      wrSel <= (strobes.commit && !rwQ) ? hitVec : '0;
      if (strobes.commit && !rwQ) begin
        wrOffset <= addrQ[OFFSET_W-1:0];
        wrData   <= dataQ;
      end
    end
  end

  // Shared interrupt flag: new events take precedence over the clear
  assign clearHit = strobes.commit & rwQ & (addrQ == ADDR_W'(STATUS_ADDR));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqPending <= 1'b0;
    else       irqPending <= (irqPending & ~clearHit) | (|irqEvent);
  end

  assign irqN = ~irqPending;

endmodule

// File: rtl/strobe_bus_slave.sv
module strobe_bus_slave
  import strobe_bus_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 4,
  parameter int NUM_PERIPH  = 4,
  parameter int OFFSET_W    = 1,
  parameter int STATUS_ADDR = 1,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_REGS   = NUM_PERIPH << OFFSET_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       busEnN,
  input  logic                       busRdWr,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic [DATA_W-1:0]          busDataIn,
  output logic [DATA_W-1:0]          busDataOut,
  output logic                       busDataOe,
  output logic                       irqN,
  input  logic [NUM_REGS*DATA_W-1:0] regRdData,
  input  logic [NUM_PERIPH-1:0]      irqEvent,
  output logic [NUM_PERIPH-1:0]      wrSel,
  output logic [OFFSET_W-1:0]        wrOffset,
  output logic [DATA_W-1:0]          wrData
);

  busStrobes_t strobes;

  strobe_bus_ctrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .busEnN (busEnN),
    .strobes(strobes)
  );

  strobe_bus_dpath #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .NUM_PERIPH (NUM_PERIPH),
    .OFFSET_W   (OFFSET_W),
    .STATUS_ADDR(STATUS_ADDR)
  ) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .busRdWr   (busRdWr),
    .busAddr   (busAddr),
    .busDataIn (busDataIn),
    .busDataOut(busDataOut),
    .busDataOe (busDataOe),
    .irqN      (irqN),
    .regRdData (regRdData),
    .irqEvent  (irqEvent),
    .wrSel     (wrSel),
    .wrOffset  (wrOffset),
    .wrData    (wrData)
  );

endmodule

// File: rtl/strobe_bus_slave_chk.sv
module strobe_bus_slave_chk #(
  parameter int NUM_PERIPH = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  busEnN,
  input logic                  busRdWr,
  input logic                  busDataOe,
  input logic                  irqN,
  input logic [NUM_PERIPH-1:0] irqEvent,
  input logic [NUM_PERIPH-1:0] wrSel
);

  AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wrSel)); // R11

  AST_WR_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (|wrSel) |=> (wrSel == '0)); // R4

  AST_NO_WR_WHILE_DRIVING: assert property (@(posedge clk) disable iff (!rstN)
    (|wrSel) |-> !busDataOe); // R5

  AST_DRIVE_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busDataOe) |-> ($past(busRdWr) && !$past(busEnN))); // R12

  AST_BUS_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busEnN, 1) && $past(busEnN, 2) && $past(busEnN, 3)) |-> !busDataOe); // R3

  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rstN)
    (|irqEvent) |=> !irqN); // R8

  AST_IRQ_CLEAR_ENDS_READ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqN) |-> $fell(busDataOe)); // R9

endmodule

bind strobe_bus_slave strobe_bus_slave_chk #(
  .NUM_PERIPH(NUM_PERIPH)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .busEnN   (busEnN),
  .busRdWr  (busRdWr),
  .busDataOe(busDataOe),
  .irqN     (irqN),
  .irqEvent (irqEvent),
  .wrSel    (wrSel)
);

// File: tb/strobe_bus_slave_test.sv
`timescale 1ns/1ps
module strobe_bus_slave_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busEnN = 1'b1;
  logic        busRdWr = 1'b1;
  logic [3:0]  busAddr = '0;
  logic [7:0]  busDataIn = '0;
  logic [7:0]  busDataOut;
  logic        busDataOe;
  logic        irqN;
  logic [63:0] regRdData;
  logic [3:0]  irqEvent = '0;
  logic [3:0]  wrSel;
  logic [0:0]  wrOffset;
  logic [7:0]  wrData;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  strobe_bus_slave uut (
    .clk(clk), .rstN(rstN), .busEnN(busEnN), .busRdWr(busRdWr),
    .busAddr(busAddr), .busDataIn(busDataIn), .busDataOut(busDataOut),
    .busDataOe(busDataOe), .irqN(irqN), .regRdData(regRdData),
    .irqEvent(irqEvent), .wrSel(wrSel), .wrOffset(wrOffset), .wrData(wrData)
  );

  function automatic logic [7:0] regVal(input int idx);
    return 8'(8'h31 + idx * 8'h13);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // {isWrite, addr, data}
  localparam logic [12:0] VEC [8] = '{
    {1'b0, 4'd0,  8'h00},
    {1'b0, 4'd1,  8'h00},
    {1'b0, 4'd7,  8'h00},
    {1'b0, 4'd9,  8'h00},
    {1'b1, 4'd2,  8'h5A},
    {1'b1, 4'd6,  8'hC3},
    {1'b1, 4'd12, 8'h77},
    {1'b0, 4'd15, 8'h00}
  };

  task automatic doRead(input logic [3:0] a, output logic [7:0] got, output logic gotOe,
                        input bit evAtClear, output logic irqAfter);
    @(negedge clk);
    busAddr = a; busRdWr = 1'b1; busEnN = 1'b0;
    repeat (3) @(negedge clk);
    got = busDataOut; gotOe = busDataOe;
    busEnN = 1'b1;
    repeat (2) @(negedge clk);
    if (evAtClear) irqEvent = 4'b0001;
    @(negedge clk);
    irqEvent = '0;
    irqAfter = irqN;
    check("R3 bus released", {31'd0, busDataOe}, 32'd0);
  endtask

  task automatic doWrite(input logic [3:0] a, input logic [7:0] d);
    logic [3:0] expSel;
    expSel = (a < 4'd8) ? 4'(1 << a[3:1]) : 4'd0;
    @(negedge clk);
    busAddr = a; busRdWr = 1'b0; busDataIn = d;
    @(negedge clk);
    busEnN = 1'b0;
    repeat (3) @(negedge clk);
    check("R12 no drive on write", {31'd0, busDataOe}, 32'd0);
    check("R5 no strobe while enable low", {28'd0, wrSel}, 32'd0);
    busEnN = 1'b1;
    repeat (2) @(negedge clk);
    check("R5 no early strobe", {28'd0, wrSel}, 32'd0);
    @(negedge clk);
    if (a < 4'd8) begin
      check("R4 R11 strobe select", {28'd0, wrSel}, {28'd0, expSel});
      check("R4 write data", {24'd0, wrData}, {24'd0, d});
      check("R4 write offset", {31'd0, wrOffset}, {31'd0, a[0]});
    end else begin
      check("R7 unmapped write ignored", {28'd0, wrSel}, 32'd0);
    end
    @(negedge clk);
    check("R4 single-cycle strobe", {28'd0, wrSel}, 32'd0);
    busDataIn = '0;
  endtask

  initial begin : watchdog
    #(200000 * 8);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [7:0] got;
    logic gotOe, irqAfter;
    for (int i = 0; i < 8; i++) regRdData[i*8 +: 8] = regVal(i);

    repeat (3) @(negedge clk);
    check("R1 reset oe", {31'd0, busDataOe}, 32'd0);
    check("R1 reset irq", {31'd0, irqN}, 32'd1);
    check("R1 reset wrSel", {28'd0, wrSel}, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after reset oe", {31'd0, busDataOe}, 32'd0);

    // Vector walk
    for (int v = 0; v < 8; v++) begin
      logic [3:0] a;
      a = VEC[v][11:8];
      if (VEC[v][12]) doWrite(a, VEC[v][7:0]);
      else begin
        doRead(a, got, gotOe, 1'b0, irqAfter);
        check("R2 read drives bus", {31'd0, gotOe}, 32'd1);
        if (a < 4'd8) check("R2 read data", {24'd0, got}, {24'd0, regVal(int'(a))});
        else          check("R6 unmapped reads FF", {24'd0, got}, 32'hFF);
      end
    end

    // Interrupt set and hold
    @(negedge clk); irqEvent = 4'b0100;
    @(negedge clk); irqEvent = '0;
    check("R8 irq asserted", {31'd0, irqN}, 32'd0);
    repeat (4) @(negedge clk);
    check("R8 irq held", {31'd0, irqN}, 32'd0);

    // Non-status read leaves it low
    doRead(4'd0, got, gotOe, 1'b0, irqAfter);
    check("R9 other read keeps irq", {31'd0, irqAfter}, 32'd0);

    // Status read clears on enable rise, data preserved
    doRead(4'd1, got, gotOe, 1'b0, irqAfter);
    check("R9 status value read", {24'd0, got}, {24'd0, regVal(1)});
    check("R9 irq released", {31'd0, irqAfter}, 32'd1);

    // Event coinciding with the clear
    @(negedge clk); irqEvent = 4'b1000;
    @(negedge clk); irqEvent = '0;
    doRead(4'd1, got, gotOe, 1'b1, irqAfter);
    check("R10 event wins over clear", {31'd0, irqAfter}, 32'd0);
    doRead(4'd1, got, gotOe, 1'b0, irqAfter);
    check("R10 later status read clears", {31'd0, irqAfter}, 32'd1);

    // Decode of every mapped register by write
    for (int a = 0; a < 8; a++) doWrite(4'(a), 8'(8'hE0 + a));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule